// File: doc/BRIEF.md
# Processor Status Register and Conditional Branch Resolver

This block keeps the eight-bit processor status byte of a small 8-bit CPU core and decides the outcome of its eight conditional relative branches. It also carries out the one-byte instructions that set or clear a single flag. The ALU reports its flag results through a per-bit enable mask and a value byte. A stack-pull path loads the whole byte at once. The stack-push path reads the `status` output directly.

Instructions arrive on a valid-qualified issue port: `op_valid`, `opcode`, `pc` (the address of the opcode byte) and `disp` (the signed displacement byte). The block accepts one instruction on every cycle and never applies back-pressure, so the port has no ready signal. A branch result leaves on a valid-qualified result port, one cycle after issue: `br_valid`, `br_taken`, `next_pc` and `br_cycles`. The consumer cannot stall this port, so it must capture the result in the cycle that `br_valid` is high. Flag writes made by an issued instruction, by the ALU mask or by a load appear on `status` one cycle later.

Status bit order, bit 7 down to bit 0: N (negative), V (overflow), U (unused, always 1), B (break), D (decimal), I (interrupt mask), Z (zero), C (carry).

Top module: `status_branch_unit`

## Requirements
- R1: After reset, `status` reads 0x24 (U and I set) and `br_valid` and `br_taken` are low.
- R2: Bit 5 of `status` reads 1 at all times, whatever value is loaded or written by the ALU.
- R3: When `sr_load` is high, `status` becomes `sr_load_data` with bit 5 forced to 1 in the next cycle. The load takes priority over ALU strobes and over flag opcodes in the same cycle.
- R4: For every bit i with `alu_flag_en[i]` high, status bit i takes `alu_flag_val[i]` in the next cycle. Bits whose enable is low keep their value.
- R5: Issued single-flag opcodes act in the next cycle: 0x18 clears C, 0x38 sets C, 0x58 clears I, 0x78 sets I, 0xB8 clears V, 0xD8 clears D, 0xF8 sets D. A flag opcode overrides an ALU strobe on the same bit in the same cycle.
- R6: The branch opcodes are taken as follows: 0x10 if N=0, 0x30 if N=1, 0x50 if V=0, 0x70 if V=1, 0x90 if C=0, 0xB0 if C=1, 0xD0 if Z=0, 0xF0 if Z=1. The test uses the status value present in the issue cycle.
- R7: One cycle after an issued branch, `br_valid` is high. `next_pc` is pc+2 plus the sign-extended `disp` when the branch is taken, and pc+2 when it is not. Arithmetic wraps modulo 2^16.
- R8: `br_cycles` is 2 for a branch that is not taken. It is 3 for a taken branch whose target has the same high byte as pc+2, and 4 for a taken branch whose target has a different high byte.
- R9: An issued opcode that is neither a branch nor a flag opcode leaves `br_valid` low and leaves `status` unchanged.
- R10: While `op_valid` is low, `opcode` has no effect: `br_valid` stays low and `status` is not changed by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue strobe for opcode, pc and disp |
| opcode | input | 8 | Instruction opcode byte |
| pc | input | 16 | Address of the opcode byte |
| disp | input | 8 | Signed branch displacement |
| alu_flag_en | input | 8 | Per-bit ALU flag write enables |
| alu_flag_val | input | 8 | ALU flag values |
| sr_load | input | 1 | Load status from stack byte |
| sr_load_data | input | 8 | Byte pulled from the stack |
| status | output | 8 | Current status byte (also the push value) |
| br_valid | output | 1 | Branch result valid, one cycle after issue |
| br_taken | output | 1 | Branch taken |
| next_pc | output | 16 | Address of the next instruction |
| br_cycles | output | 3 | Branch cost in cycles (2, 3 or 4) |

## Verification
Every result arrives one register stage after its stimulus. A branch issued in cycle n shows `br_valid`, `br_taken`, `next_pc` and `br_cycles` in cycle n+1. A load, an ALU strobe or a flag opcode applied in cycle n shows on `status` in cycle n+1. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It samples the outputs at that same falling edge, after exactly one rising edge. The branch sweep first loads each combination of N, V, Z and C and waits one cycle for it to appear. It then issues every branch opcode with displacements and PC values that cover forward, backward, same-page and page-crossing targets.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int SR_W  = 8;
  localparam int BIT_C = 0;
  localparam int BIT_Z = 1;
  localparam int BIT_I = 2;
  localparam int BIT_D = 3;
  localparam int BIT_B = 4;
  localparam int BIT_U = 5;
  localparam int BIT_V = 6;
  localparam int BIT_N = 7;

  typedef enum logic [1:0] {
    COND_NEG  = 2'd0,
    COND_OVF  = 2'd1,
    COND_CRY  = 2'd2,
    COND_ZERO = 2'd3
  } cond_sel_e;

  localparam logic [2:0] CYC_BASE = 3'd2;
endpackage

// File: rtl/sbr_decode.sv
module sbr_decode
  import sbr_pkg::*;
(
  input  logic [7:0] opcode,
  output logic       is_branch,
  output cond_sel_e  cond_sel,
  output logic       cond_want,
  output logic       is_flag_op,
  output logic [2:0] flag_idx,
  output logic       flag_val
);
  // Branches share the low pattern 1_0000; bits 7:6 pick the flag, bit 5 the wanted level
  assign is_branch = (opcode[4:0] == 5'b10000);
  assign cond_sel  = cond_sel_e'(opcode[7:6]);
  assign cond_want = opcode[5];

  always_comb begin
    is_flag_op = 1'b0;
    flag_idx   = 3'(BIT_C);
    flag_val   = 1'b0;
    if (opcode[4:0] == 5'b11000) begin
      unique case (opcode[7:5])
        3'b000: begin is_flag_op = 1'b1; flag_idx = 3'(BIT_C); flag_val = 1'b0; end
        3'b001: begin is_flag_op = 1'b1; flag_idx = 3'(BIT_C); flag_val = 1'b1; end
        3'b010: begin is_flag_op = 1'b1; flag_idx = 3'(BIT_I); flag_val = 1'b0; end
        3'b011: begin is_flag_op = 1'b1; flag_idx = 3'(BIT_I); flag_val = 1'b1; end
        3'b101: begin is_flag_op = 1'b1; flag_idx = 3'(BIT_V); flag_val = 1'b0; end
        3'b110: begin is_flag_op = 1'b1; flag_idx = 3'(BIT_D); flag_val = 1'b0; end
        3'b111: begin is_flag_op = 1'b1; flag_idx = 3'(BIT_D); flag_val = 1'b1; end
        default: is_flag_op = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sbr_flags.sv
module sbr_flags
  import sbr_pkg::*;
#(
  parameter logic [SR_W-1:0] RESET_SR = 8'h24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SR_W-1:0] load_data,
  input  logic [SR_W-1:0] alu_en,
  input  logic [SR_W-1:0] alu_val,
  input  logic            set_en,
  input  logic [2:0]      set_idx,
  input  logic            set_val,
  output logic [SR_W-1:0] status
);
  logic [SR_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    for (int i = 0; i < SR_W; i++) begin
      if (alu_en[i]) sr_d[i] = alu_val[i];
    end
    if (set_en) sr_d[set_idx] = set_val;
    if (load)   sr_d = load_data;
    sr_d[BIT_U] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= RESET_SR | (SR_W'(1) << BIT_U);
    else        sr_q <= sr_d;
  end

  assign status = sr_q;

  // R3
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> status == ($past(load_data) | 8'h20));

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && alu_en == '0 && !set_en) |=> $stable(status));

  // R4
  alu_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !set_en) |=> ((status ^ $past(status)) & ~$past(alu_en)) == '0);
endmodule

// File: rtl/sbr_target.sv
module sbr_target #(
  parameter int PC_W     = 16,
  parameter int DISP_W   = 8,
  parameter int PAGE_LSB = 8,
  parameter int INSN_LEN = 2
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  output logic [PC_W-1:0]   seq_pc,
  output logic [PC_W-1:0]   tgt_pc,
  output logic              page_cross
);
  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] disp_ext;

  assign disp_ext   = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign seq_pc     = pc + PC_W'(INSN_LEN);
  assign tgt_pc     = seq_pc + disp_ext;
  assign page_cross = (seq_pc[PC_W-1:PAGE_LSB] != tgt_pc[PC_W-1:PAGE_LSB]);
endmodule

// File: rtl/status_branch_unit.sv
module status_branch_unit
  import sbr_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int DISP_W   = 8,
  parameter int PAGE_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        opcode,
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  input  logic [SR_W-1:0]   alu_flag_en,
  input  logic [SR_W-1:0]   alu_flag_val,
  input  logic              sr_load,
  input  logic [SR_W-1:0]   sr_load_data,
  output logic [SR_W-1:0]   status,
  output logic              br_valid,
  output logic              br_taken,
  output logic [PC_W-1:0]   next_pc,
  output logic [2:0]        br_cycles
);
  logic       is_branch, cond_want, is_flag_op, flag_val;
  cond_sel_e  cond_sel;
  logic [2:0] flag_idx;
  logic [PC_W-1:0] seq_pc, tgt_pc;
  logic       page_cross, cond_flag, take;

  sbr_decode u_dec (
    .opcode    (opcode),
    .is_branch (is_branch),
    .cond_sel  (cond_sel),
    .cond_want (cond_want),
    .is_flag_op(is_flag_op),
    .flag_idx  (flag_idx),
    .flag_val  (flag_val)
  );

  sbr_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sr_load),
    .load_data(sr_load_data),
    .alu_en   (alu_flag_en),
    .alu_val  (alu_flag_val),
    .set_en   (op_valid && is_flag_op),
    .set_idx  (flag_idx),
    .set_val  (flag_val),
    .status   (status)
  );

  sbr_target #(.PC_W(PC_W), .DISP_W(DISP_W), .PAGE_LSB(PAGE_LSB)) u_tgt (
    .pc        (pc),
    .disp      (disp),
    .seq_pc    (seq_pc),
    .tgt_pc    (tgt_pc),
    .page_cross(page_cross)
  );

  always_comb begin
    unique case (cond_sel)
      COND_NEG:  cond_flag = status[BIT_N];
      COND_OVF:  cond_flag = status[BIT_V];
      COND_CRY:  cond_flag = status[BIT_C];
      default:   cond_flag = status[BIT_Z];
    endcase
  end

  assign take = (cond_flag == cond_want);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      br_valid  <= 1'b0;
      br_taken  <= 1'b0;
      next_pc   <= '0;
      br_cycles <= CYC_BASE;
    end else begin
      br_valid <= op_valid && is_branch;
      br_taken <= op_valid && is_branch && take;
      if (op_valid && is_branch) begin
        next_pc   <= take ? tgt_pc : seq_pc;
        br_cycles <= CYC_BASE + 3'(take) + 3'(take && page_cross);
      end
    end
  end

  // R7
  branch_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_branch) |=> br_valid);

  // R10
  idle_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !br_valid);

  // R8
  not_taken_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !br_taken) |-> br_cycles == 3'd2);

  // R8
  taken_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_taken) |-> (br_cycles == 3'd3 || br_cycles == 3'd4));

  // R2
  unused_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[BIT_U]);
endmodule

// File: tb/status_branch_unit_test.sv
module status_branch_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] pc = 16'h0000;
  logic [7:0]  disp = 8'h00;
  logic [7:0]  alu_flag_en = 8'h00;
  logic [7:0]  alu_flag_val = 8'h00;
  logic        sr_load = 1'b0;
  logic [7:0]  sr_load_data = 8'h00;
  logic [7:0]  status;
  logic        br_valid, br_taken;
  logic [15:0] next_pc;
  logic [2:0]  br_cycles;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_branch_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .pc(pc), .disp(disp), .alu_flag_en(alu_flag_en), .alu_flag_val(alu_flag_val),
    .sr_load(sr_load), .sr_load_data(sr_load_data), .status(status),
    .br_valid(br_valid), .br_taken(br_taken), .next_pc(next_pc), .br_cycles(br_cycles)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_sr(input logic [7:0] v);
    sr_load = 1'b1; sr_load_data = v;
    @(negedge clk);
    sr_load = 1'b0;
  endtask

  task automatic issue(input logic [7:0] op, input logic [15:0] p, input logic [7:0] d);
    op_valid = 1'b1; opcode = op; pc = p; disp = d;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  function automatic bit exp_take(input logic [7:0] op, input logic [7:0] s);
    case (op)
      8'h10: return !s[7];
      8'h30: return s[7];
      8'h50: return !s[6];
      8'h70: return s[6];
      8'h90: return !s[0];
      8'hB0: return s[0];
      8'hD0: return !s[1];
      default: return s[1];
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] brs [8] = '{8'h10, 8'h30, 8'h50, 8'h70, 8'h90, 8'hB0, 8'hD0, 8'hF0};
    logic [7:0] fops [7] = '{8'h18, 8'h38, 8'h58, 8'h78, 8'hB8, 8'hD8, 8'hF8};
    logic [7:0] dsel [4] = '{8'h00, 8'h7F, 8'h80, 8'hFD};
    logic [15:0] psel [3] = '{16'h12F0, 16'h1240, 16'hFFFE};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", status, 8'h24);
    check("R1 br_valid", br_valid, 0);
    check("R1 br_taken", br_taken, 0);

    // R2/R3 load forces bit 5
    load_sr(8'h00);
    check("R2 bit5 on zero load", status, 8'h20);
    load_sr(8'hDF);
    check("R3 load value", status, 8'hFF);

    // R6/R7/R8 exhaustive branch sweep
    for (int op = 0; op < 8; op++) begin
      for (int f = 0; f < 16; f++) begin
        for (int di = 0; di < 4; di++) begin
          for (int pi = 0; pi < 3; pi++) begin
            logic [7:0] s;
            logic [15:0] seq, tgt;
            bit tk, cr;
            s = {f[3], f[2], 4'b0000, f[1], f[0]};
            load_sr(s);
            issue(brs[op], psel[pi], dsel[di]);
            tk  = exp_take(brs[op], s);
            seq = psel[pi] + 16'd2;
            tgt = seq + {{8{dsel[di][7]}}, dsel[di]};
            cr  = (seq[15:8] != tgt[15:8]);
            check("R7 br_valid", br_valid, 1);
            check("R6 br_taken", br_taken, tk);
            check("R7 next_pc", next_pc, tk ? tgt : seq);
            check("R8 br_cycles", br_cycles, tk ? (cr ? 4 : 3) : 2);
            check("R9 branch keeps status", status, s | 8'h20);
          end
        end
      end
    end

    // R5 flag opcodes from all-zero and all-one starts
    for (int st = 0; st < 2; st++) begin
      for (int k = 0; k < 7; k++) begin
        logic [7:0] s, e;
        s = st ? 8'hFF : 8'h00;
        load_sr(s);
        issue(fops[k], 16'h0000, 8'h00);
        e = s | 8'h20;
        case (fops[k])
          8'h18: e[0] = 0;  8'h38: e[0] = 1;
          8'h58: e[2] = 0;  8'h78: e[2] = 1;
          8'hB8: e[6] = 0;  8'hD8: e[3] = 0;
          default: e[3] = 1;
        endcase
        check("R5 flag op", status, e);
        check("R9 flag op no branch", br_valid, 0);
      end
    end

    // R4 every ALU mask
    for (int m = 0; m < 256; m++) begin
      load_sr(8'hA5);
      alu_flag_en = 8'(m); alu_flag_val = 8'h5A;
      @(negedge clk);
      alu_flag_en = 8'h00;
      check("R4 alu mask", status, ((8'hA5 & ~8'(m)) | (8'h5A & 8'(m))) | 8'h20);
    end

    // R9 every other opcode
    load_sr(8'hC3);
    for (int o = 0; o < 256; o++) begin
      if (o[4:0] != 5'b10000 && !(o[4:0] == 5'b11000 && o[7:5] != 3'b100)) begin
        issue(8'(o), 16'h3000, 8'h10);
        check("R9 other op status", status, 8'hE3);
        check("R9 other op br_valid", br_valid, 0);
      end
    end

    // R10 op_valid low: branch and flag opcodes ignored
    load_sr(8'h00);
    opcode = 8'h10; pc = 16'h0100; disp = 8'h05;
    @(negedge clk);
    check("R10 idle branch", br_valid, 0);
    opcode = 8'h38;
    @(negedge clk);
    check("R10 idle flag op", status, 8'h20);

    // R3 priority: load beats ALU and flag op
    sr_load = 1'b1; sr_load_data = 8'h00;
    alu_flag_en = 8'hFF; alu_flag_val = 8'hFF;
    op_valid = 1'b1; opcode = 8'h38;
    @(negedge clk);
    sr_load = 1'b0; alu_flag_en = 8'h00; op_valid = 1'b0;
    check("R3 load priority", status, 8'h20);

    // R5 flag op beats ALU on same bit
    alu_flag_en = 8'h01; alu_flag_val = 8'h01;
    op_valid = 1'b1; opcode = 8'h18;
    @(negedge clk);
    alu_flag_en = 8'h00; op_valid = 1'b0;
    check("R5 flag op over alu", status, 8'h20);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule